// File: doc/BRIEF.md
# Escaped Byte Stream Command and Memory Write Decoder

This block sits behind a byte-wide host FIFO and turns one undivided byte stream into two kinds of action. The byte 0xA5 is an escape prefix. An escape followed by a second 0xA5 stands for one literal 0xA5 data byte. An escape followed by any other byte is an in-band control command that sets or clears one of four persistent flags, or fires a one-cycle parser reset pulse.

All bytes that are not part of a command are paired into 16-bit words, low byte first. A command may arrive between the two halves of a word without disturbing it. The words form framed memory writes. Each frame is a target word (board number and DAC index), a first address, a last address, and then one data word for every address from first to last inclusive. Frames aimed at a different board are parsed in full but produce no write strobes. The write port gives a DAC index, a memory address that wraps at the memory depth, and the data word.

Top module: `esc_write_decoder`

## Requirements
- R1: An escape byte 0xA5 followed by a second 0xA5 yields exactly one data byte of value 0xA5. Any number of idle cycles may separate the two bytes.
- R2: An escape followed by a byte C other than 0xA5 is a command. C[7:1] selects the target and C[0]=0 sets it, C[0]=1 clears it. The targets are C[7:1]=1 for `trig_flag`, 2 for `arm_flag`, 3 for `clk2x_flag` and 4 for `start_flag`. A flag changes in the cycle after the command byte is accepted and holds until another command for it arrives.
- R3: The byte pair 0xA5 0x00 drives `parse_reset` high for exactly one cycle after the 0x00 is accepted. It discards any pending low byte, returns the parser to expecting a target word, and leaves all flags unchanged. The pair 0xA5 0x01 has no effect.
- R4: Commands whose C[7:1] is 5 or higher change no flag, cause no pulse and leave word assembly untouched.
- R5: Data bytes are paired into 16-bit words. The first byte of a pair is bits [7:0] and the second is bits [15:8].
- R6: A command received between the low and high byte of a word leaves the pending low byte intact.
- R7: A frame consists of a target word, a first address F and a last address L. It is followed by L-F+1 (mod 65536) data words written to F, F+1, and so on up to L. After the last data word, the next word is taken as a new target word.
- R8: The target word carries the board number in bits [7:4] and the DAC index in bits [3:0]. `wr_chan` shows the DAC index. A frame whose board number differs from `board_addr` produces no `wr_en`, but its words are consumed exactly as in R7.
- R9: The 16-bit address counter wraps from 0xFFFF to 0x0000. `wr_addr` is its low log2(MEM_DEPTH) bits, so addresses wrap at the memory depth.
- R10: `wr_en` is high for exactly one cycle, in the cycle after the byte that completes a data word is accepted. A cycle with `in_valid` low changes no output.
- R11: After hardware reset, all flags, `wr_en` and `parse_reset` are low, no escape or low byte is pending, and the parser expects a target word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is presented on `in_byte` this cycle |
| in_byte | input | 8 | Stream byte |
| board_addr | input | 4 | Local board number compared against target word bits [7:4] |
| parse_reset | output | 1 | One-cycle pulse from the reset command |
| trig_flag | output | 1 | Soft trigger flag |
| arm_flag | output | 1 | Arm flag |
| clk2x_flag | output | 1 | Fast clock select flag |
| start_flag | output | 1 | Frame start enable flag |
| wr_en | output | 1 | Memory write strobe |
| wr_chan | output | 4 | DAC index of the current frame |
| wr_addr | output | log2(MEM_DEPTH) | Write address, wrapped at the memory depth |
| wr_data | output | 16 | Write data word |

## Verification
The hardest situations to reach from the ports are the ones where escape handling and word assembly overlap:
- an escape-escape literal split by idle cycles;
- a command wedged between the two halves of a data word;
- a reset command arriving while a low byte is pending in the middle of a frame.

The stimulus builds these directly as byte sequences, and uses address ranges that cross both the memory depth and the 16-bit counter limit. A behavioural byte-level model in the bench steps once per clock and is compared with every output on every cycle, so a stray write strobe or flag change is caught in the cycle it occurs.

// File: rtl/esc_write_decoder.sv
module esc_write_decoder #(
  parameter int MEM_DEPTH = 8192,
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic [3:0]    board_addr,
  output logic          parse_reset,
  output logic          trig_flag,
  output logic          arm_flag,
  output logic          clk2x_flag,
  output logic          start_flag,
  output logic          wr_en,
  output logic [3:0]    wr_chan,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data
);

  localparam logic [7:0] ESC = 8'hA5;

  typedef enum logic [1:0] {P_CHAN, P_FIRST, P_LAST, P_DATA} pstate_t;

  pstate_t     st;
  logic        esc_q;
  logic        have_lo;
  logic [7:0]  lo_q;
  logic        sel_q;
  logic [15:0] cur_q;
  logic [15:0] last_q;

  wire         is_lead   = in_valid && !esc_q && (in_byte == ESC);
  wire         is_cmd    = in_valid && esc_q && (in_byte != ESC);
  wire         is_data   = in_valid && (esc_q ? (in_byte == ESC) : (in_byte != ESC));
  wire [6:0]   cmd_code  = in_byte[7:1];
  wire         cmd_on    = ~in_byte[0];
  wire         do_reset  = is_cmd && (in_byte == 8'h00);
  wire [15:0]  word      = {in_byte, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= P_CHAN;
      esc_q       <= 1'b0;
      have_lo     <= 1'b0;
      lo_q        <= '0;
      sel_q       <= 1'b0;
      cur_q       <= '0;
      last_q      <= '0;
      parse_reset <= 1'b0;
      trig_flag   <= 1'b0;
      arm_flag    <= 1'b0;
      clk2x_flag  <= 1'b0;
      start_flag  <= 1'b0;
      wr_en       <= 1'b0;
      wr_chan     <= '0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      parse_reset <= do_reset;
      wr_en       <= 1'b0;
      if (in_valid) esc_q <= is_lead;
      if (is_cmd) begin
        case (cmd_code)
          7'd1:    trig_flag  <= cmd_on;
          7'd2:    arm_flag   <= cmd_on;
          7'd3:    clk2x_flag <= cmd_on;
          7'd4:    start_flag <= cmd_on;
          default: ;
        endcase
      end
      if (do_reset) begin
        have_lo <= 1'b0;
        st      <= P_CHAN;
      end else if (is_data) begin
        if (!have_lo) begin
          lo_q    <= in_byte;
          have_lo <= 1'b1;
        end else begin
          have_lo <= 1'b0;
          case (st)
            P_CHAN: begin
              sel_q   <= (word[7:4] == board_addr);
              wr_chan <= word[3:0];
              st      <= P_FIRST;
            end
            P_FIRST: begin
              cur_q <= word;
              st    <= P_LAST;
            end
            P_LAST: begin
              last_q <= word;
              st     <= P_DATA;
            end
            default: begin
              wr_en   <= sel_q;
              wr_addr <= cur_q[AW-1:0];
              wr_data <= word;
              cur_q   <= cur_q + 16'd1;
              if (cur_q == last_q) st <= P_CHAN;
            end
          endcase
        end
      end
    end
  end

  assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wr_en && !parse_reset));

  assert_reset_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    parse_reset |=> !parse_reset);

  assert_reset_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    parse_reset |-> !wr_en);

  assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({trig_flag, arm_flag, clk2x_flag, start_flag}));

  assert_reset_keeps_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    parse_reset |-> $stable({trig_flag, arm_flag, clk2x_flag, start_flag}));

endmodule

// File: tb/tb_esc_write_decoder.sv
module tb_esc_write_decoder;
  localparam int MEM = 8192;
  localparam int AWT = $clog2(MEM);
  localparam int BOARD = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [7:0] in_byte = 0;
  logic [3:0] board_addr = BOARD[3:0];
  logic parse_reset, trig_flag, arm_flag, clk2x_flag, start_flag, wr_en;
  logic [3:0] wr_chan;
  logic [AWT-1:0] wr_addr;
  logic [15:0] wr_data;

  esc_write_decoder #(.MEM_DEPTH(MEM)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .board_addr(board_addr), .parse_reset(parse_reset), .trig_flag(trig_flag),
    .arm_flag(arm_flag), .clk2x_flag(clk2x_flag), .start_flag(start_flag),
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_addr(wr_addr), .wr_data(wr_data));

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit running = 0;

  int    q_v[$];
  int    q_b[$];
  string q_t[$];
  string cur_tag = "R11 reset state";

  int m_esc = 0, m_have = 0, m_lo = 0, m_state = 0, m_sel = 0, m_chan = 0;
  int m_cur = 0, m_last = 0;
  int m_trig = 0, m_arm = 0, m_clk = 0, m_start = 0;
  int m_rst = 0, m_wr = 0, m_wa = 0, m_wd = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual %0h expected %0h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("parse_reset", int'(parse_reset), m_rst);
    chk("trig_flag", int'(trig_flag), m_trig);
    chk("arm_flag", int'(arm_flag), m_arm);
    chk("clk2x_flag", int'(clk2x_flag), m_clk);
    chk("start_flag", int'(start_flag), m_start);
    chk("wr_en", int'(wr_en), m_wr);
    if (m_wr) begin
      chk("wr_chan", int'(wr_chan), m_chan);
      chk("wr_addr", int'(wr_addr), m_wa);
      chk("wr_data", int'(wr_data), m_wd);
    end
  endtask

  task automatic model(int v, int b);
    int w;
    m_wr = 0;
    m_rst = 0;
    if (!v) return;
    if (!m_esc && b == 8'hA5) begin
      m_esc = 1;
      return;
    end
    if (m_esc && b != 8'hA5) begin
      m_esc = 0;
      case (b >> 1)
        0: if (!(b & 1)) begin m_rst = 1; m_have = 0; m_state = 0; end
        1: m_trig  = !(b & 1);
        2: m_arm   = !(b & 1);
        3: m_clk   = !(b & 1);
        4: m_start = !(b & 1);
        default: ;
      endcase
      return;
    end
    m_esc = 0;
    if (!m_have) begin
      m_lo = b;
      m_have = 1;
      return;
    end
    m_have = 0;
    w = (b << 8) | m_lo;
    case (m_state)
      0: begin m_sel = (((w >> 4) & 15) == BOARD); m_chan = w & 15; m_state = 1; end
      1: begin m_cur = w; m_state = 2; end
      2: begin m_last = w; m_state = 3; end
      default: begin
        if (m_sel) begin m_wr = 1; m_wa = m_cur % MEM; m_wd = w; end
        if (m_cur == m_last) m_state = 0;
        m_cur = (m_cur + 1) & 16'hFFFF;
      end
    endcase
  endtask

  task automatic push_raw(int v, int b, string t);
    q_v.push_back(v); q_b.push_back(b); q_t.push_back(t);
  endtask
  task automatic push_byte(int b, string t);
    if (b == 8'hA5) push_raw(1, 8'hA5, t);
    push_raw(1, b, t);
  endtask
  task automatic push_word(int w, string t);
    push_byte(w & 255, t);
    push_byte((w >> 8) & 255, t);
  endtask
  task automatic push_cmd(int c, string t);
    push_raw(1, 8'hA5, t);
    push_raw(1, c, t);
  endtask
  task automatic push_idle(int n, string t);
    for (int i = 0; i < n; i++) push_raw(0, 0, t);
  endtask

  always @(negedge clk) begin
    if (running) begin
      compare();
      if (q_v.size() > 0) begin
        in_valid = q_v[0][0];
        in_byte  = q_b[0][7:0];
        cur_tag  = q_t[0];
        model(q_v.pop_front(), q_b.pop_front());
        void'(q_t.pop_front());
      end else begin
        in_valid = 0;
        in_byte  = 0;
        model(0, 0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog R10: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2 set each flag, then clear two of them
    push_cmd(8'h02, "R2 trig on");
    push_cmd(8'h04, "R2 arm on");
    push_cmd(8'h06, "R2 clk2x on");
    push_cmd(8'h08, "R2 start on");
    push_idle(3, "R10 idle holds flags");
    push_cmd(8'h03, "R2 trig off");
    push_cmd(8'h09, "R2 start off");
    // R4 unknown codes change nothing
    push_cmd(8'h0A, "R4 unknown code");
    push_cmd(8'hFE, "R4 unknown code");
    // R7 R5 three-word write to this board
    push_word(16'h0052, "R7 target word");
    push_word(16'h0010, "R7 first addr");
    push_word(16'h0012, "R7 last addr");
    push_word(16'h1234, "R5 R7 data 0");
    push_word(16'hBEEF, "R7 data 1");
    push_raw(0, 0, "R10 gap");
    push_word(16'h0F0E, "R7 data 2");
    // R1 escaped literals, one split by idle cycles
    push_word(16'h0051, "R1 target");
    push_word(16'h0100, "R1 first");
    push_word(16'h0101, "R1 last");
    push_word(16'hA5A5, "R1 literal A5A5");
    push_raw(1, 8'hA5, "R1 split escape");
    push_idle(2, "R1 split escape");
    push_raw(1, 8'hA5, "R1 split escape");
    push_byte(8'h3C, "R1 split escape");
    // R6 command between bytes of a word
    push_word(16'h0053, "R6 target");
    push_word(16'h0020, "R6 first");
    push_word(16'h0020, "R6 last");
    push_byte(8'h77, "R6 low byte");
    push_cmd(8'h02, "R6 command mid-word");
    push_cmd(8'h01, "R3 0xA5 0x01 has no effect");
    push_byte(8'h66, "R6 high byte");
    // R8 foreign board consumes frame without writes
    push_word(16'h0032, "R8 foreign target");
    push_word(16'h0000, "R8 first");
    push_word(16'h0001, "R8 last");
    push_word(16'hAAAA, "R8 no write");
    push_word(16'hBBBB, "R8 no write");
    push_word(16'h0154, "R8 upper bits ignored target");
    push_word(16'h0005, "R8 first");
    push_word(16'h0005, "R8 last");
    push_word(16'h4242, "R8 own board write");
    // R3 reset mid-frame with pending low byte
    push_word(16'h0051, "R3 target");
    push_word(16'h0030, "R3 first");
    push_word(16'h0033, "R3 last");
    push_word(16'h1111, "R3 data before reset");
    push_byte(8'h99, "R3 pending low byte");
    push_cmd(8'h00, "R3 reset command");
    push_word(16'h0052, "R3 fresh target");
    push_word(16'h0040, "R3 first");
    push_word(16'h0040, "R3 last");
    push_word(16'h2222, "R3 write after reset");
    // R9 wrap at memory depth and at 16-bit counter
    push_word(16'h0051, "R9 target");
    push_word(16'h1FFF, "R9 first");
    push_word(16'h2001, "R9 last");
    push_word(16'h0001, "R9 depth wrap");
    push_word(16'h0002, "R9 depth wrap");
    push_word(16'h0003, "R9 depth wrap");
    push_word(16'h0050, "R9 target");
    push_word(16'hFFFF, "R9 first");
    push_word(16'h0001, "R9 last");
    push_word(16'h00A1, "R9 counter wrap");
    push_word(16'h00A2, "R9 counter wrap");
    push_word(16'h00A3, "R9 counter wrap");
    push_cmd(8'h07, "R2 clk2x off");
    push_idle(4, "R10 trailing idle");

    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    running = 1;
    wait (q_v.size() == 0);
    repeat (3) @(negedge clk);
    running = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule